// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the two least significant address bits for a four-beat memory burst. Either of two active-low start strobes begins a burst. One strobe is driven by a processor and the other by a controller. At that edge the block captures a 2-bit start value and resets its beat counter. After the start edge the counter moves forward one beat for each qualified advance request. After the fourth beat it wraps, so the address returns to the start value.

A mode input selects the count order. When `interleave` is high, the address is the start value XOR the beat count. When it is low, the address is the start value plus the beat count, modulo four. Designs with no mode control should tie `interleave` high. An advance is qualified only when the advance request is low and both strobes are high. If the burst was started as a write, an advance also needs the byte-enable summary input to be low. The block does not decode the upper address or touch the memory array.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst_n` is low, and after it is released with no other stimulus, `burst_addr` reads 0 and `beat` reads 0.
- R2: A clock edge that samples `cpu_start_n` low, `ctl_start_n` low, or both, loads `start_addr`. After that edge `beat` is 0 and `burst_addr` equals the loaded start value.
- R3: With `interleave` high (1), `burst_addr` equals start XOR `beat`. For example, a start of 1 gives the sequence 1, 0, 3, 2.
- R4: With `interleave` low (0), `burst_addr` equals (start + `beat`) mod 4. For example, a start of 1 gives the sequence 1, 2, 3, 0.
- R5: An edge that samples `adv_n` low with both strobes high, during a read burst, increments `beat` by one.
- R6: An edge that samples `adv_n` high, with both strobes high, leaves `beat` and `burst_addr` unchanged.
- R7: A load edge ignores `adv_n`. If `adv_n` is sampled low on the same edge, `beat` is still 0 after it.
- R8: A burst is a write when `wr_cycle` is 1 at its load edge. In a write burst, `beat` advances only when `adv_n` and `byte_en_n` are both sampled low. In a read burst, `byte_en_n` has no effect.
- R9: The fourth qualified advance after a load returns `beat` to 0 and `burst_addr` to the start value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_start_n | input | 1 | Processor start strobe, active low |
| ctl_start_n | input | 1 | Controller start strobe, active low |
| start_addr | input | 2 | Start value captured on a load edge |
| wr_cycle | input | 1 | Marks the burst as a write, sampled on the load edge |
| byte_en_n | input | 1 | Low when any byte lane is enabled; qualifies write advances |
| adv_n | input | 1 | Advance request, active low |
| interleave | input | 1 | Order select: 1 for XOR order, 0 for linear wrap |
| burst_addr | output | 2 | Current burst address bits |
| beat | output | 2 | Beats advanced since the last load |

## Verification
All state updates on the rising edge that samples the strobes and the advance inputs. Both `beat` and `burst_addr` are therefore due one edge after the stimulus. `burst_addr` also follows `interleave` combinationally within the same cycle. The driver applies each stimulus at a falling edge and pushes the expected pair for the next rising edge. The monitor samples 2 ns after that rising edge and compares against the head of the queue, so each vector is judged against exactly one edge.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int unsigned BURST_AW    = 2;
  localparam int unsigned BURST_BEATS = 1 << BURST_AW;

  typedef logic [BURST_AW-1:0] bidx_t;

  // Wrap-around order: start offset by beat count, modulo the burst length.
  function automatic bidx_t order_linear(bidx_t start, bidx_t cnt);
    return bidx_t'(start + cnt);
  endfunction

  // Interleaved order: start with beat-count bits flipped in.
  function automatic bidx_t order_xor(bidx_t start, bidx_t cnt);
    return start ^ cnt;
  endfunction
endpackage

// File: rtl/burst_step_qual.sv
module burst_step_qual (
  input  logic cpu_start_n,
  input  logic ctl_start_n,
  input  logic adv_n,
  input  logic byte_en_n,
  input  logic wr_burst,
  output logic load_ev,
  output logic step_ev
);
  logic lane_ok;

  always_comb begin
    load_ev = ~cpu_start_n | ~ctl_start_n;
    lane_ok = ~wr_burst | ~byte_en_n;
    // A load on this edge wins over any advance request.
    step_ev = ~load_ev & ~adv_n & lane_ok;
  end
endmodule

// File: rtl/burst_beat_cnt.sv
module burst_beat_cnt #(
  parameter int unsigned AW = burst_seq_pkg::BURST_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_ev,
  input  logic          step_ev,
  input  logic [AW-1:0] start_addr,
  input  logic          wr_cycle,
  output logic [AW-1:0] base_q,
  output logic [AW-1:0] beat_q,
  output logic          wr_q
);
  localparam logic [AW-1:0] ONE = AW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      beat_q <= '0;
      wr_q   <= 1'b0;
    end else if (load_ev) begin
      base_q <= start_addr;
      beat_q <= '0;
      wr_q   <= wr_cycle;
    end else if (step_ev) begin
      beat_q <= beat_q + ONE;
    end
  end
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_seq_pkg::*;
(
  input  bidx_t base,
  input  bidx_t cnt,
  input  logic  interleave,
  output bidx_t addr
);
  bidx_t lin_addr;
  bidx_t xor_addr;

  always_comb begin
    lin_addr = order_linear(base, cnt);
    xor_addr = order_xor(base, cnt);
    addr     = interleave ? xor_addr : lin_addr;
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_seq_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cpu_start_n,
  input  logic                ctl_start_n,
  input  logic [BURST_AW-1:0] start_addr,
  input  logic                wr_cycle,
  input  logic                byte_en_n,
  input  logic                adv_n,
  input  logic                interleave,
  output logic [BURST_AW-1:0] burst_addr,
  output logic [BURST_AW-1:0] beat
);
  logic  load_ev;
  logic  step_ev;
  logic  wr_q;
  bidx_t base_q;
  bidx_t beat_q;

  burst_step_qual u_qual (
    .cpu_start_n (cpu_start_n),
    .ctl_start_n (ctl_start_n),
    .adv_n       (adv_n),
    .byte_en_n   (byte_en_n),
    .wr_burst    (wr_q),
    .load_ev     (load_ev),
    .step_ev     (step_ev)
  );

  burst_beat_cnt #(.AW(BURST_AW)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_ev    (load_ev),
    .step_ev    (step_ev),
    .start_addr (start_addr),
    .wr_cycle   (wr_cycle),
    .base_q     (base_q),
    .beat_q     (beat_q),
    .wr_q       (wr_q)
  );

  burst_order_map u_map (
    .base       (base_q),
    .cnt        (beat_q),
    .interleave (interleave),
    .addr       (burst_addr)
  );

  assign beat = beat_q;
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cpu_start_n,
  input logic       ctl_start_n,
  input logic [1:0] start_addr,
  input logic       adv_n,
  input logic       byte_en_n,
  input logic       interleave,
  input logic       wr_q,
  input logic       load_ev,
  input logic       step_ev,
  input logic [1:0] base_q,
  input logic [1:0] burst_addr,
  input logic [1:0] beat
);
  a_r1_reset_zero: assert property (@(posedge clk) !rst_n |-> beat == 2'd0);

  a_r2_load_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_start_n || !ctl_start_n) |=> (beat == 2'd0 && base_q == $past(start_addr)));

  a_r3_xor_first: assert property (@(posedge clk) disable iff (!rst_n)
    (interleave && beat == 2'd0) |-> burst_addr == base_q);

  a_r4_linear_first: assert property (@(posedge clk) disable iff (!rst_n)
    (!interleave && beat == 2'd0) |-> burst_addr == base_q);

  a_r5_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_start_n && ctl_start_n && !adv_n && !wr_q) |=> beat == $past(beat) + 2'd1);

  a_r6_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_start_n && ctl_start_n && adv_n) |=> $stable(beat));

  a_r7_load_beats_step: assert property (@(posedge clk) disable iff (!rst_n)
    load_ev |-> !step_ev);

  a_r8_write_needs_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_start_n && ctl_start_n && wr_q && byte_en_n) |=> $stable(beat));

  a_r9_wrap_home: assert property (@(posedge clk) disable iff (!rst_n)
    (step_ev && beat == 2'd3) |=> beat == 2'd0);
endmodule

bind burst_addr_gen burst_addr_gen_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cpu_start_n (cpu_start_n),
  .ctl_start_n (ctl_start_n),
  .start_addr  (start_addr),
  .adv_n       (adv_n),
  .byte_en_n   (byte_en_n),
  .interleave  (interleave),
  .wr_q        (wr_q),
  .load_ev     (load_ev),
  .step_ev     (step_ev),
  .base_q      (base_q),
  .burst_addr  (burst_addr),
  .beat        (beat)
);

// File: tb/tb_burst_addr_gen.sv
`timescale 1ns/1ps
module tb_burst_addr_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_start_n = 1'b1;
  logic       ctl_start_n = 1'b1;
  logic [1:0] start_addr = 2'd0;
  logic       wr_cycle = 1'b0;
  logic       byte_en_n = 1'b1;
  logic       adv_n = 1'b1;
  logic       interleave = 1'b1;
  logic [1:0] burst_addr;
  logic [1:0] beat;

  always #4 clk = ~clk;  // 125 MHz

  burst_addr_gen dut (
    .clk(clk), .rst_n(rst_n), .cpu_start_n(cpu_start_n), .ctl_start_n(ctl_start_n),
    .start_addr(start_addr), .wr_cycle(wr_cycle), .byte_en_n(byte_en_n),
    .adv_n(adv_n), .interleave(interleave), .burst_addr(burst_addr), .beat(beat)
  );

  typedef struct { logic [1:0] addr; logic [1:0] bt; string tag; } exp_t;
  exp_t q[$];
  int vectors = 0;
  int misses  = 0;
  bit done    = 0;

  // Bench model state
  int  m_start = 0;
  int  m_beat  = 0;
  bit  m_wr    = 0;

  function automatic int model_addr(int s, int b, bit il);
    int a;
    if (il) begin
      a = 0;
      for (int k = 0; k < 2; k++)
        if (((s >> k) & 1) != ((b >> k) & 1)) a += (1 << k);
    end else begin
      a = s;
      for (int k = 0; k < b; k++) a = (a == 3) ? 0 : a + 1;
    end
    return a;
  endfunction

  task automatic cyc(bit cpu_n, bit ctl_n, int st, bit wr, bit ben_n, bit av_n,
                     bit il, string tag);
    exp_t e;
    @(negedge clk);
    cpu_start_n = cpu_n; ctl_start_n = ctl_n; start_addr = 2'(st);
    wr_cycle = wr; byte_en_n = ben_n; adv_n = av_n; interleave = il;
    if (!cpu_n || !ctl_n) begin
      m_start = st; m_beat = 0; m_wr = wr;
    end else if (!av_n && (!m_wr || !ben_n)) begin
      m_beat = (m_beat + 1) % 4;
    end
    e.addr = 2'(model_addr(m_start, m_beat, il));
    e.bt   = 2'(m_beat);
    e.tag  = tag;
    q.push_back(e);
  endtask

  task automatic idle(bit il, string tag);
    cyc(1, 1, 0, 0, 1, 1, il, tag);
  endtask

  // Monitor: compares one queued item per rising edge.
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      vectors++;
      if (burst_addr !== e.addr || beat !== e.bt) begin
        misses++;
        $display("FAIL %s: addr=%0d beat=%0d expected addr=%0d beat=%0d",
                 e.tag, burst_addr, beat, e.addr, e.bt);
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      misses++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk);
    if (burst_addr !== 2'd0 || beat !== 2'd0) begin
      misses++;
      $display("FAIL R1: addr=%0d beat=%0d expected addr=0 beat=0", burst_addr, beat);
    end
    vectors++;
    @(negedge clk); rst_n = 1'b1;
    idle(1, "R1");

    // R2/R3/R4/R6/R9: every start in both orders, with stalls.
    for (int md = 1; md >= 0; md--) begin
      for (int s = 0; s < 4; s++) begin
        string ord;
        ord = md ? "R3" : "R4";
        if (s[0]) cyc(0, 1, s, 0, 1, 1, md[0], "R2");
        else      cyc(1, 0, s, 0, 1, 1, md[0], "R2");
        cyc(1, 1, 0, 0, 1, 0, md[0], ord);   // R5 advance
        idle(md[0], "R6");                    // stall
        cyc(1, 1, 0, 0, 1, 0, md[0], ord);
        cyc(1, 1, 0, 0, 0, 0, md[0], "R8");   // read: lane input irrelevant
        idle(md[0], "R6");
        cyc(1, 1, 0, 0, 1, 0, md[0], "R9");   // wrap to start
      end
    end

    // R7: load with advance low on same edge, both strobes
    cyc(1, 1, 0, 0, 1, 0, 1, "R5");
    cyc(0, 1, 2, 0, 1, 0, 1, "R7");
    cyc(1, 0, 3, 0, 1, 0, 0, "R7");
    cyc(0, 0, 1, 0, 1, 0, 1, "R7");

    // R8: write burst needs lane enable
    cyc(1, 0, 2, 1, 1, 1, 0, "R2");
    cyc(1, 1, 0, 0, 1, 0, 0, "R8");       // blocked
    cyc(1, 1, 0, 0, 0, 0, 0, "R8");       // steps
    cyc(1, 1, 0, 0, 0, 1, 0, "R6");       // lane low, adv high: hold
    cyc(1, 1, 0, 0, 0, 0, 1, "R8");
    cyc(1, 1, 0, 0, 1, 0, 1, "R8");       // blocked
    // mode flip mid-burst changes order immediately
    idle(0, "R4");
    idle(1, "R3");

    idle(1, "R6");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule